// File: doc/BRIEF.md
# Column Command Turnaround Gate

This block guards the command bus of a memory channel carrying two DIMMs with two ranks each. Every column command (read or write) must be separated from the one before it by a minimum number of clocks. That minimum depends on three things: the type of the previous command, the type of the new one, and how the two targets relate. The targets can be the same rank, another rank on the same DIMM, or a different DIMM.

The block remembers the type and target of the last command it let through. It counts the clocks that have passed since then. It grants a new request only once the gap chosen for that pair has passed. Each gap is a programmed amount added to a base. The base is either a fixed 2-clock preset, the burst length, or a minimum computed from the read and write latencies.

Granted commands are driven onto registered command and chip-select pins. In single-clock command mode, the command and its chip select appear together for one clock. In two-clock mode, the command pins are set up one clock early and hold for two clocks, and the chip select fires only in the second of those clocks.

Top module: `rank_turnaround_gate`

## Requirements
- R1: After reset `cmd_o` is 0 and `cs_o` is all zero, and the first valid request after reset is granted (`issue_o` high) in the same cycle it is presented.
- R2: Read followed by read needs at least BURST+`rd_rd_same` clocks between grants on the same rank, 2+`rd_rd_rank` clocks on another rank of the same DIMM, and 2+`rd_rd_dimm` clocks on a different DIMM. BURST defaults to 4. The target index is {dimm, rank}, and the DIMM is its upper bit.
- R3: Write followed by write uses the same three-way rule with `wr_wr_same`, `wr_wr_rank` and `wr_wr_dimm`.
- R4: Read followed by a write to the same rank needs B+`rd_wr_same` clocks. Here B = `cas_lat`+BURST+2−`wr_lat`, floored at 2.
- R5: Read followed by a write to any other rank or DIMM needs 2+`rd_wr_other` clocks.
- R6: Write followed by read, to any target, needs `wr_lat`+BURST+`wr_rd_add` clocks.
- R7: In single-clock mode (`two_n`=0), a grant in cycle t puts the command code on `cmd_o` in cycle t+1 for exactly one clock. The code is 2'b10 for read and 2'b11 for write. In the same cycle, `cs_o` carries a one-hot bit at the target index.
- R8: In two-clock mode (`two_n`=1), a grant in cycle t drives the command code on `cmd_o` in cycles t+1 and t+2. `cs_o` stays zero in t+1 and is one-hot at the target in t+2.
- R9: `issue_o` is never high without `req_valid`. A request that is not presented causes no command on the pins.
- R10: The elapsed-clock count saturates. After an idle stretch longer than the largest possible gap, any request is granted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A column command is requested |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dimm | input | DIMM_W | Target DIMM |
| req_rank | input | RANK_W | Target rank within the DIMM |
| two_n | input | 1 | 1 selects two-clock command mode |
| cas_lat | input | CFG_W | Read latency used in computed bases |
| wr_lat | input | CFG_W | Write latency used in computed bases |
| rd_rd_same | input | CFG_W | Read-read add, same rank |
| rd_rd_rank | input | CFG_W | Read-read add, other rank same DIMM |
| rd_rd_dimm | input | CFG_W | Read-read add, other DIMM |
| wr_wr_same | input | CFG_W | Write-write add, same rank |
| wr_wr_rank | input | CFG_W | Write-write add, other rank same DIMM |
| wr_wr_dimm | input | CFG_W | Write-write add, other DIMM |
| rd_wr_same | input | CFG_W | Read-write add, same rank |
| rd_wr_other | input | CFG_W | Read-write add, other rank or DIMM |
| wr_rd_add | input | CFG_W | Write-read add |
| issue_o | output | 1 | Request granted this cycle |
| cmd_o | output | 2 | Command pins: 00 none, 10 read, 11 write |
| cs_o | output | 2**(DIMM_W+RANK_W) | One-hot chip selects, active high |

## Verification
The bench sweeps every pairing of previous and next command type and target, 64 pairs in all. It does so under two timing sets, one of which drives the computed read-to-write base to its floor, and it repeats the sweep in both command modes. For each pair it counts clocks until the grant. A gap table with swapped rank and DIMM entries, or with a wrong base, would give the wrong count for exactly the affected pairs.

The bench also checks the pin waveform after each first grant. A design that asserted chip select in the first clock of a two-clock command, or left the command on the bus longer than required, would be caught there. Further checks confirm that the first request after reset is not stalled by a cleared counter, and that long idle periods do not wrap the elapsed count.

// File: rtl/rank_turnaround_gate.sv
module rank_turnaround_gate #(
  parameter int CFG_W  = 4,
  parameter int DIMM_W = 1,
  parameter int RANK_W = 1,
  parameter int BURST  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DIMM_W-1:0] req_dimm,
  input  logic [RANK_W-1:0] req_rank,
  input  logic              two_n,
  input  logic [CFG_W-1:0]  cas_lat,
  input  logic [CFG_W-1:0]  wr_lat,
  input  logic [CFG_W-1:0]  rd_rd_same,
  input  logic [CFG_W-1:0]  rd_rd_rank,
  input  logic [CFG_W-1:0]  rd_rd_dimm,
  input  logic [CFG_W-1:0]  wr_wr_same,
  input  logic [CFG_W-1:0]  wr_wr_rank,
  input  logic [CFG_W-1:0]  wr_wr_dimm,
  input  logic [CFG_W-1:0]  rd_wr_same,
  input  logic [CFG_W-1:0]  rd_wr_other,
  input  logic [CFG_W-1:0]  wr_rd_add,
  output logic              issue_o,
  output logic [1:0]        cmd_o,
  output logic [(1<<(DIMM_W+RANK_W))-1:0] cs_o
);
  localparam int TGT_W = DIMM_W + RANK_W;
  localparam int CS_N  = 1 << TGT_W;
  localparam int CNT_W = CFG_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] TWO     = CNT_W'(2);
  localparam logic [CNT_W-1:0] BL      = CNT_W'(BURST);

  function automatic logic [CNT_W-1:0] ext(input logic [CFG_W-1:0] v);
    return {2'b00, v};
  endfunction

  logic              first_q, last_wr_q, pre_q, sel_q;
  logic [TGT_W-1:0]  last_tgt_q, tgt_q;
  logic [CNT_W-1:0]  elapsed_q, gap, rw_base, rw_sum;
  logic [1:0]        cmd_q;
  logic [TGT_W-1:0]  req_tgt;
  logic              same_dimm, same_rank;

  assign req_tgt   = {req_dimm, req_rank};
  assign same_dimm = req_dimm == last_tgt_q[TGT_W-1:RANK_W];
  assign same_rank = req_tgt == last_tgt_q;
  assign rw_sum    = ext(cas_lat) + BL + TWO;
  assign rw_base   = (rw_sum > ext(wr_lat) + TWO) ? rw_sum - ext(wr_lat) : TWO;

  always_comb begin
    unique case ({last_wr_q, req_write})
      2'b00:   gap = same_rank ? BL + ext(rd_rd_same)
                   : same_dimm ? TWO + ext(rd_rd_rank) : TWO + ext(rd_rd_dimm);
      2'b11:   gap = same_rank ? BL + ext(wr_wr_same)
                   : same_dimm ? TWO + ext(wr_wr_rank) : TWO + ext(wr_wr_dimm);
      2'b01:   gap = same_rank ? rw_base + ext(rd_wr_same) : TWO + ext(rd_wr_other);
      default: gap = ext(wr_lat) + BL + ext(wr_rd_add);
    endcase
  end

  assign issue_o = req_valid && !pre_q && (first_q || elapsed_q >= gap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q    <= 1'b1;
      last_wr_q  <= 1'b0;
      last_tgt_q <= '0;
      elapsed_q  <= '0;
    end else if (issue_o) begin
      first_q    <= 1'b0;
      last_wr_q  <= req_write;
      last_tgt_q <= req_tgt;
      elapsed_q  <= CNT_W'(1);
    end else if (elapsed_q != CNT_MAX) begin
      elapsed_q  <= elapsed_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 2'b00;
      tgt_q <= '0;
      pre_q <= 1'b0;
      sel_q <= 1'b0;
    end else if (issue_o) begin
      cmd_q <= {1'b1, req_write};
      tgt_q <= req_tgt;
      pre_q <= two_n;
      sel_q <= !two_n;
    end else if (pre_q) begin
      pre_q <= 1'b0;
      sel_q <= 1'b1;
    end else if (sel_q) begin
      sel_q <= 1'b0;
      cmd_q <= 2'b00;
    end
  end

  assign cmd_o = cmd_q;

  for (genvar i = 0; i < CS_N; i++) begin : g_cs
    assign cs_o[i] = sel_q && (tgt_q == TGT_W'(i));
  end

  a_r7_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o));
  a_r7_cs_has_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (|cs_o) |-> cmd_o[1]);
  a_r8_cs_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (two_n && $stable(two_n) && (|cs_o)) |-> (cmd_o == $past(cmd_o)));
  a_r9_issue_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |-> req_valid);
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |=> !issue_o);
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed_q == CNT_MAX) |=> (elapsed_q == CNT_MAX || elapsed_q == CNT_W'(1)));
endmodule

// File: tb/rank_turnaround_gate_test.sv
module rank_turnaround_gate_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_write, two_n;
  logic [0:0] req_dimm, req_rank;
  logic [3:0] cas_lat, wr_lat, rd_rd_same, rd_rd_rank, rd_rd_dimm;
  logic [3:0] wr_wr_same, wr_wr_rank, wr_wr_dimm, rd_wr_same, rd_wr_other, wr_rd_add;
  logic       issue_o;
  logic [1:0] cmd_o;
  logic [3:0] cs_o;

  int errors = 0;
  int checks = 0;

  rank_turnaround_gate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_dimm(req_dimm), .req_rank(req_rank), .two_n(two_n),
    .cas_lat(cas_lat), .wr_lat(wr_lat),
    .rd_rd_same(rd_rd_same), .rd_rd_rank(rd_rd_rank), .rd_rd_dimm(rd_rd_dimm),
    .wr_wr_same(wr_wr_same), .wr_wr_rank(wr_wr_rank), .wr_wr_dimm(wr_wr_dimm),
    .rd_wr_same(rd_wr_same), .rd_wr_other(rd_wr_other), .wr_rd_add(wr_rd_add),
    .issue_o(issue_o), .cmd_o(cmd_o), .cs_o(cs_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_gap(input bit lw, input int lt, input bit nw, input int nt);
    bit sd, sr;
    int b;
    sd = (lt >> 1) == (nt >> 1);
    sr = lt == nt;
    if (!lw && !nw) return sr ? 4 + int'(rd_rd_same) : sd ? 2 + int'(rd_rd_rank) : 2 + int'(rd_rd_dimm);
    if (lw && nw)   return sr ? 4 + int'(wr_wr_same) : sd ? 2 + int'(wr_wr_rank) : 2 + int'(wr_wr_dimm);
    if (!lw && nw) begin
      if (!sr) return 2 + int'(rd_wr_other);
      b = int'(cas_lat) + 6;
      b = (b > int'(wr_lat) + 2) ? b - int'(wr_lat) : 2;
      return b + int'(rd_wr_same);
    end
    return int'(wr_lat) + 4 + int'(wr_rd_add);
  endfunction

  function automatic string tag(input bit lw, input bit nw, input bit sr);
    if (!lw && !nw) return "R2";
    if (lw && nw) return "R3";
    if (!lw && nw) return sr ? "R4" : "R5";
    return "R6";
  endfunction

  task automatic drive(input bit v, input bit w, input int t);
    req_valid = v;
    req_write = w;
    req_dimm  = 1'(t >> 1);
    req_rank  = 1'(t);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(cmd_o == 2'b00, "R1 cmd after reset", cmd_o, 0);
    check(cs_o == 4'b0000, "R1 cs after reset", cs_o, 0);
    drive(1, 1, 2);
    #1;
    check(issue_o == 1'b1, "R1 first request immediate", issue_o, 1);
    @(negedge clk);
    drive(0, 0, 0);
  endtask

  task automatic pair(input bit lw, input int lt, input bit nw, input int nt);
    int n;
    int e;
    logic [1:0] code;
    code = {1'b1, lw};
    repeat (70) @(negedge clk);
    #1;
    check(issue_o == 1'b0 && cmd_o == 2'b00 && cs_o == 4'b0, "R9 idle no command", issue_o, 0);
    drive(1, lw, lt);
    #1;
    check(issue_o == 1'b1, "R10 grant after idle", issue_o, 1);
    @(negedge clk);
    drive(1, nw, nt);
    n = 1;
    while (n < 80) begin
      #1;
      if (n == 1) begin
        check(cmd_o == code, two_n ? "R8 cmd first clock" : "R7 cmd", cmd_o, code);
        check(cs_o == (two_n ? 4'b0 : 4'(1 << lt)), two_n ? "R8 cs low first clock" : "R7 cs",
              cs_o, two_n ? 0 : (1 << lt));
      end
      if (n == 2) begin
        check(cmd_o == (two_n ? code : 2'b00), two_n ? "R8 cmd held" : "R7 cmd one clock",
              cmd_o, two_n ? code : 0);
        check(cs_o == (two_n ? 4'(1 << lt) : 4'b0), two_n ? "R8 cs second clock" : "R7 cs one clock",
              cs_o, two_n ? (1 << lt) : 0);
      end
      if (issue_o) break;
      @(negedge clk);
      n++;
    end
    e = exp_gap(lw, lt, nw, nt);
    check(n == e, tag(lw, nw, lt == nt), n, e);
    @(negedge clk);
    drive(0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    two_n = 1'b0;
    drive(0, 0, 0);
    for (int set = 0; set < 2; set++) begin
      if (set == 0) begin
        cas_lat = 9;  wr_lat = 7;
        rd_rd_same = 1; rd_rd_rank = 3; rd_rd_dimm = 2;
        wr_wr_same = 0; wr_wr_rank = 4; wr_wr_dimm = 5;
        rd_wr_same = 2; rd_wr_other = 6; wr_rd_add = 1;
      end else begin
        cas_lat = 5;  wr_lat = 12;
        rd_rd_same = 3; rd_rd_rank = 0; rd_rd_dimm = 7;
        wr_wr_same = 2; wr_wr_rank = 6; wr_wr_dimm = 1;
        rd_wr_same = 0; rd_wr_other = 3; wr_rd_add = 5;
      end
      for (int m = 0; m < 2; m++) begin
        two_n = 1'(m);
        do_reset();
        for (int k = 0; k < 64; k++) begin
          pair(1'(k >> 5), (k >> 3) & 3, 1'(k >> 2), k & 3);
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule